// File: doc/BRIEF.md
# Two-Phase Differential SAR Sequencer

This block is the digital controller behind a fully differential capacitive-DAC converter with two comparators. After a start request it runs an auto-zero interval for the comparator. It then performs a short coarse search on the negative-side DAC, driven by a low-power comparator. The purpose of that search is to keep the comparator input near common mode. The block then runs the full binary search on the positive-side DAC, driven by the precision comparator. The raw result is the positive code minus the negative code.

Three conversion flavours are chosen at start. Differential mode runs both phases. Single-ended mode skips the coarse search. Low-resolution mode also skips the coarse search and resolves only the upper bits of the positive code. Each trial bit takes two clock cycles. In the first cycle the comparator clock is high, which resets the comparator while the DAC settles. In the second cycle the comparator clock is low and the comparator decides; its output is taken at the end of that cycle. Calibration, the analog DACs and the comparators lie outside this block.

Top module: `dsar_seq`

## Requirements
- R1: In differential mode (mode 2'b00, and also 2'b11) a 5-step search runs first on `neg_dac`. It is driven by `cmp_lp` and resolves bits 15:11 only. Bits 10:0 of `neg_dac` stay 0 at all times.
- R2: After the negative phase, a 16-step search runs on `pos_dac`, driven by `cmp_pr`, MSB first. `pos_dac` is 0 throughout the negative phase.
- R3: `result` is the 17-bit two's-complement value of the positive code minus the negative code. The negative code keeps its bits in positions 15:11.
- R4: In single-ended mode (mode 2'b01) no negative step runs, and `neg_dac` stays 0.
- R5: In low-resolution mode (mode 2'b10) only 12 positive steps run, on bits 15:4. Bits 3:0 of the code are 0, and no negative step runs.
- R6: On an accepted start, `az_out` and `az_in` are both high for AZ_CYC cycles (default 2). `az_out` is released first and `az_in` one cycle later, and both are low before the first trial. `az_out` is never high while `az_in` is low.
- R7: For each step, the trial bit is shown for one cycle with `cmp_clk` high and then one cycle with `cmp_clk` low. The comparator is sampled at the end of the low cycle: 1 keeps the bit and 0 clears it.
- R8: `done` is high for exactly one cycle. Counting the cycles after the accepting edge, it rises in cycle AZ_CYC+1+2·(negative steps)+2·(positive steps)+1. `result` is valid from then until the next accepted start.
- R9: A `start` that arrives while `busy` is high is ignored. The conversion length and the result are unchanged.
- R10: After reset, `busy`, `done`, `az_out` and `az_in` are low, and both DAC buses are 0.
- R11: `mode` is captured at the accepted start. Changes to it during a conversion have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request, taken only while idle |
| mode | input | 2 | 00 differential, 01 single-ended, 10 low-resolution, 11 differential |
| cmp_lp | input | 1 | Low-power comparator decision for the negative side |
| cmp_pr | input | 1 | Precision comparator decision for the positive side |
| busy | output | 1 | Conversion in progress, including the done cycle |
| done | output | 1 | One-cycle result-valid pulse |
| cmp_clk | output | 1 | High: comparator reset and DAC settling; low: compare |
| az_out | output | 1 | Comparator output-stage zero control |
| az_in | output | 1 | Comparator input zero control |
| neg_dac | output | DATA_W | Negative-side DAC bit controls |
| pos_dac | output | DATA_W | Positive-side DAC bit controls |
| result | output | DATA_W+1 | Signed raw result, positive code minus negative code |

## Verification
The comparators are modelled as ideal threshold tests against two target codes, so each mode must converge to a value the bench can predict.

- Inputs at full scale on one side and zero on the other separate a correct subtraction from a swapped one. They also check the sign extension of the 17-bit result.
- A mid-scale pattern with nonzero low bits on the negative target shows whether the coarse search wrongly resolves bits below 11.
- The same targets run in single-ended and low-resolution modes show whether the negative phase is skipped and whether the low bits are masked.
- A start pulse, together with a mode change, injected mid-conversion tells an ignored request apart from a restart or a re-read of the mode.

// File: rtl/dsar_pkg.sv
package dsar_pkg;

   typedef enum logic [1:0] {
      MODE_DIFF     = 2'b00,
      MODE_SINGLE   = 2'b01,
      MODE_LORES    = 2'b10,
      MODE_DIFF_ALT = 2'b11
   } conv_mode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PREP,
      ST_NSET,
      ST_NCMP,
      ST_PSET,
      ST_PCMP,
      ST_DONE
   } seq_state_e;

   function automatic logic mode_has_neg(input logic [1:0] m);
      return (m == MODE_DIFF) || (m == MODE_DIFF_ALT);
   endfunction

endpackage

// File: rtl/sar_bit_walker.sv
// Successive-approximation register: holds decided bits and a one-hot trial mask.
module sar_bit_walker #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         present,
   input  logic         decide,
   input  logic         keep,
   output logic [W-1:0] dac,
   output logic [W-1:0] code
);

   logic [W-1:0] code_q;
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         mask_q <= '0;
      end else if (clr) begin
         code_q <= '0;
         mask_q <= {1'b1, {(W-1){1'b0}}};
      end else if (decide) begin
         if (keep) code_q <= code_q | mask_q;
         mask_q <= mask_q >> 1;
      end
   end

   assign dac  = code_q | (present ? mask_q : '0);
   assign code = code_q;

   // Trial mask never carries more than one bit (R7)
   p_mask_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mask_q));

   // A decision never changes a bit above the current trial (R7)
   p_decided_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !clr) |=> ((code_q & ~$past(mask_q)) == ($past(code_q) & ~$past(mask_q))));

endmodule

// File: rtl/sar_az_ctrl.sv
// Auto-zero sequencer: both controls high, then output stage released, then input.
module sar_az_ctrl #(
   parameter int AZ_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic begin_i,
   output logic az_out,
   output logic az_in,
   output logic fin
);

   localparam int CW = (AZ_CYC < 2) ? 1 : $clog2(AZ_CYC);

   typedef enum logic [1:0] {AZ_OFF, AZ_HOLD, AZ_GAP} az_state_e;

   az_state_e         st_q;
   logic [CW-1:0]     cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= AZ_OFF;
         cnt_q <= '0;
      end else begin
         unique case (st_q)
            AZ_OFF: if (begin_i) begin
               st_q  <= AZ_HOLD;
               cnt_q <= '0;
            end
            AZ_HOLD: begin
               if (cnt_q == CW'(AZ_CYC-1)) st_q <= AZ_GAP;
               else                        cnt_q <= cnt_q + 1'b1;
            end
            AZ_GAP:  st_q <= AZ_OFF;
            default: st_q <= AZ_OFF;
         endcase
      end
   end

   assign az_out = (st_q == AZ_HOLD);
   assign az_in  = (st_q == AZ_HOLD) || (st_q == AZ_GAP);
   assign fin    = (st_q == AZ_GAP);

   // Output-stage control is never held while the input control is released (R6)
   p_az_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      az_out |-> az_in);

   // Input control falls exactly one cycle after the output-stage control (R6)
   p_az_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(az_out) |=> $fell(az_in));

endmodule

// File: rtl/dsar_seq.sv
module dsar_seq
   import dsar_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int NEG_STEPS = 5,
   parameter int LR_STEPS  = 12,
   parameter int AZ_CYC    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   input  logic              cmp_lp,
   input  logic              cmp_pr,
   output logic              busy,
   output logic              done,
   output logic              cmp_clk,
   output logic              az_out,
   output logic              az_in,
   output logic [DATA_W-1:0] neg_dac,
   output logic [DATA_W-1:0] pos_dac,
   output logic [DATA_W:0]   result
);

   localparam int RES_W = DATA_W + 1;
   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam int NEG_LOW = DATA_W - NEG_STEPS;

   if (NEG_STEPS < 1 || NEG_STEPS >= DATA_W) begin : g_bad_neg
      $error("NEG_STEPS must lie in 1..DATA_W-1");
   end
   if (LR_STEPS < 1 || LR_STEPS > DATA_W) begin : g_bad_lr
      $error("LR_STEPS must lie in 1..DATA_W");
   end
   if (AZ_CYC < 1) begin : g_bad_az
      $error("AZ_CYC must be at least 1");
   end

   seq_state_e       state_q;
   logic [1:0]       mode_q;
   logic [CNT_W-1:0] step_q;
   logic             accept;
   logic             az_fin;
   logic [CNT_W-1:0] pos_last;
   logic [DATA_W-1:0] neg_code, pos_code;

   assign accept   = (state_q == ST_IDLE) && start;
   assign pos_last = (mode_q == MODE_LORES) ? CNT_W'(LR_STEPS-1) : CNT_W'(DATA_W-1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_DIFF;
         step_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_PREP;
               mode_q  <= mode;
            end
            ST_PREP: if (az_fin) begin
               state_q <= mode_has_neg(mode_q) ? ST_NSET : ST_PSET;
               step_q  <= '0;
            end
            ST_NSET: state_q <= ST_NCMP;
            ST_NCMP: begin
               if (step_q == CNT_W'(NEG_STEPS-1)) begin
                  state_q <= ST_PSET;
                  step_q  <= '0;
               end else begin
                  state_q <= ST_NSET;
                  step_q  <= step_q + 1'b1;
               end
            end
            ST_PSET: state_q <= ST_PCMP;
            ST_PCMP: begin
               if (step_q == pos_last) begin
                  state_q <= ST_DONE;
               end else begin
                  state_q <= ST_PSET;
                  step_q  <= step_q + 1'b1;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   sar_az_ctrl #(.AZ_CYC(AZ_CYC)) u_az (
      .clk    (clk),
      .rst_n  (rst_n),
      .begin_i(accept),
      .az_out (az_out),
      .az_in  (az_in),
      .fin    (az_fin)
   );

   sar_bit_walker #(.W(DATA_W)) u_neg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .present((state_q == ST_NSET) || (state_q == ST_NCMP)),
      .decide (state_q == ST_NCMP),
      .keep   (cmp_lp),
      .dac    (neg_dac),
      .code   (neg_code)
   );

   sar_bit_walker #(.W(DATA_W)) u_pos (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (accept),
      .present((state_q == ST_PSET) || (state_q == ST_PCMP)),
      .decide (state_q == ST_PCMP),
      .keep   (cmp_pr),
      .dac    (pos_dac),
      .code   (pos_code)
   );

   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_DONE);
   assign cmp_clk = !((state_q == ST_NCMP) || (state_q == ST_PCMP));
   assign result  = RES_W'({1'b0, pos_code}) - RES_W'({1'b0, neg_code});

   // Coarse search never reaches below its bit range (R1)
   p_neg_low_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      neg_dac[NEG_LOW-1:0] == '0);

   // Positive DAC idle while the negative phase runs (R2)
   p_pos_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_NSET) || (state_q == ST_NCMP)) |-> (pos_dac == '0));

   // Negative DAC untouched outside differential conversions (R4)
   p_neg_unused_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mode_has_neg(mode_q)) |-> (neg_dac == '0));

   // Low-resolution codes carry no bits below the resolved range (R5)
   p_lores_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == MODE_LORES) |-> (pos_dac[DATA_W-LR_STEPS-1:0] == '0));

   // Every compare half is followed by a reset half (R7)
   p_cmp_alt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_clk |=> cmp_clk);

   // Comparator is never clocked during auto-zero (R6)
   p_no_cmp_in_az_r6: assert property (@(posedge clk) disable iff (!rst_n)
      az_in |-> cmp_clk);

   // Done is a single-cycle pulse (R8)
   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // Result held while idle with no new start (R8)
   p_result_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result));

endmodule

// File: tb/dsar_seq_tb.sv
`timescale 1ns/1ps
module dsar_seq_tb;

   localparam int AZC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        cmp_lp, cmp_pr;
   logic        busy, done, cmp_clk, az_out, az_in;
   logic [15:0] neg_dac, pos_dac;
   logic [16:0] result;
   logic [15:0] vin_p = '0, vin_n = '0;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   assign cmp_pr = (pos_dac <= vin_p);
   assign cmp_lp = (neg_dac <= vin_n);

   dsar_seq u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .cmp_lp(cmp_lp), .cmp_pr(cmp_pr), .busy(busy), .done(done),
      .cmp_clk(cmp_clk), .az_out(az_out), .az_in(az_in),
      .neg_dac(neg_dac), .pos_dac(pos_dac), .result(result)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic test_reset();
      chk("R10 busy", busy, 0);
      chk("R10 done", done, 0);
      chk("R10 az", {az_out, az_in}, 0);
      chk("R10 dacs", {neg_dac, pos_dac}, 0);
   endtask

   // One conversion; poke = inject start and mode change mid-run
   task automatic run_conv(input logic [1:0] m, input logic [15:0] vp, input logic [15:0] vn,
                           input bit poke, input string tag);
      int nneg, npos, kdone, kazo, kazi, lows, neglows, k;
      bit neg_low_bad, neg_used, order_bad;
      logic [15:0] pexp, nexp;
      logic [16:0] rexp;
      nneg = (m == 2'b00 || m == 2'b11) ? 5 : 0;
      npos = (m == 2'b10) ? 12 : 16;
      nexp = (nneg != 0) ? (vn & 16'hF800) : 16'h0;
      pexp = (m == 2'b10) ? (vp & 16'hFFF0) : vp;
      rexp = {1'b0, pexp} - {1'b0, nexp};
      vin_p = vp; vin_n = vn;
      @(negedge clk); mode = m; start = 1'b1;
      @(negedge clk); start = 1'b0;
      k = 1; kdone = 0; kazo = 0; kazi = 0; lows = 0; neglows = 0;
      neg_low_bad = 0; neg_used = 0; order_bad = 0;
      while (kdone == 0 && k < 200) begin
         if (poke && k == 12) begin start = 1'b1; mode = ~m; end
         if (poke && k == 13) begin start = 1'b0; mode = m; end
         if (!az_out && kazo == 0) kazo = k;
         if (!az_in && kazi == 0) kazi = k;
         if (az_out && !az_in) order_bad = 1;
         if (neg_dac[10:0] != 0) neg_low_bad = 1;
         if (neg_dac != 0) neg_used = 1;
         if (!cmp_clk) begin
            lows++;
            if (pos_dac == 0) neglows++;
         end
         if (k == AZC + 2 + 2*nneg)
            chk({"R7 trial shown with cmp_clk high ", tag}, {cmp_clk, pos_dac}, {1'b1, 16'h8000});
         if (k == AZC + 3 + 2*nneg)
            chk({"R7 compare half low ", tag}, cmp_clk, 0);
         if (done) kdone = k;
         @(negedge clk); k++;
      end
      chk({"R6 az_out release cycle ", tag}, kazo, AZC + 1);
      chk({"R6 az_in release one later ", tag}, kazi, AZC + 2);
      chk({"R6 release order ", tag}, order_bad, 0);
      chk({"R8 done cycle ", tag}, kdone, AZC + 1 + 2*nneg + 2*npos + 1);
      chk({"R8 done one cycle ", tag}, {done, busy}, 0);
      chk({"R3 result ", tag}, result, rexp);
      chk({"R7 compare count ", tag}, lows, nneg + npos);
      if (nneg != 0) begin
         chk({"R1 negative steps ", tag}, neglows, 5);
         chk({"R1 negative low bits ", tag}, neg_low_bad, 0);
         chk({"R1 negative code ", tag}, neg_dac, nexp);
      end else begin
         chk({"R4 negative unused ", tag}, neg_used, 0);
      end
      chk({"R2 positive code ", tag}, pos_dac, pexp);
      if (m == 2'b10) chk({"R5 low bits zero ", tag}, pos_dac[3:0], 0);
      repeat (3) @(negedge clk);
      chk({"R8 result held ", tag}, result, rexp);
   endtask

   initial begin
      #5_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_conv(2'b00, 16'hFFFF, 16'h0000, 0, "diff full");
      run_conv(2'b00, 16'h0000, 16'hFFFF, 0, "diff negative");
      run_conv(2'b00, 16'h8A5C, 16'h4FFF, 0, "diff mid");
      run_conv(2'b11, 16'h1234, 16'hC7FF, 0, "diff alt code");
      run_conv(2'b01, 16'hBEEF, 16'hFFFF, 0, "R4 single");
      run_conv(2'b10, 16'h1237, 16'hFFFF, 0, "R5 lores");
      run_conv(2'b10, 16'hFFFF, 16'h0000, 0, "R5 lores full");
      run_conv(2'b00, 16'h7777, 16'h3333, 1, "R9 R11 busy start");
      run_conv(2'b01, 16'h0001, 16'h0000, 1, "R9 R11 single poke");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule